// File: doc/BRIEF.md
# Two-Bank Address Translation Map with Rotating Bank Replacement

This block translates a virtual address into a physical address through a two-way, bank-associative map. The virtual address is split into an alias tag (top bits), a slot index and a word offset. A status RAM holds one 2-bit entry per map page (tag plus slot). It tells whether a translation is present and which of two map banks holds it. Each bank is indexed by the slot alone, so every slot can hold translations for at most two of the aliasing tags at once.

A lookup reads the status entry and the selected bank entry in the same cycle. It returns a registered response one cycle later: a map miss, an access fault, or a physical address with the entry's attribute bits. A refill installs one new map entry. A usage table keeps one record per pair of adjacent slots, so both map pages of a two-slot page share a bank. The record names the tag that owns each bank and which bank to replace next. It can also pin the left bank for a wired page. A refill picks a bank, invalidates both status entries of the evicted owner, writes the bank entry, updates the usage record and marks the new status valid. This runs as a short multi-cycle sequence, and lookups are held off while it runs.

With `SLOT_W = 14`, `TAG_W = 3` and `OFF_W = 8`, the slot is virtual bits [21:8], the tag is [24:22] and the status index is [24:8]. The defaults are smaller so the storage stays compact.

Top module: `vmap_two_bank`

## Requirements
- R1: The status entry of a map page is addressed by `lk_va[VA_W-1:OFF_W]`. Bit 0 is valid and bit 1 selects the bank (1 = right, 0 = left). After reset every status entry is invalid, so every lookup reports a miss.
- R2: Each bank is addressed by the slot bits `va[OFF_W+SLOT_W-1:OFF_W]`. A bank entry holds:
  - access at [31];
  - status at [30:28];
  - representation at [27:26];
  - oldspace at [25];
  - volatility at [24:23];
  - cache inhibit at [22];
  - physical page number at [21:0].
  On a valid lookup `rsp_attr` returns entry bits [31:22]. On a miss `rsp_attr` is zero.
- R3: Two different tags can be mapped at the same slot pair at the same time. Installing a third tag evicts one of them.
- R4: A lookup with a clear valid bit gives `rsp_miss=1` and `rsp_fault=0`. A valid lookup faults when:
  - bit 31 of the entry is clear; or
  - it is a write and bit 30 of the entry is clear.
  Otherwise the lookup succeeds.
- R5: On success `rsp_pa` = {entry[21:0], `lk_va[OFF_W-1:0]`, 2'b00}. On a miss or a fault `rsp_pa` is zero.
- R6: The next-bank field of a usage record is encoded as follows:
  - 00: wired;
  - 01: use right next;
  - 10: use left next.
  Records reset to "use left next", with both owner fields all ones (unused). After a non-wired install into a newly chosen bank, the field names the other bank.
- R7: When the chosen bank has an owner, the owner's two map pages at that slot pair become invalid. The owner's map pages are found from the owner field's low tag bits and the current slot pair. An all-ones owner field evicts nothing.
- R8: If the incoming tag already owns a bank at the pair, that bank is reused. Nothing is evicted and the next-bank field is unchanged.
- R9: A wired refill always installs into the left bank and sets the next field to wired. From then on, refills of other tags at that pair go to the right bank, so the wired page stays mapped.
- R10: A refill is accepted on a clock edge where `rf_valid` and `rf_ready` are both high. After that edge:
  - `rf_busy` is high for exactly 4 cycles;
  - `rf_ready` and `lk_ready` are low during those cycles;
  - `rf_done` is high for the single cycle after `rf_busy` falls.
- R11: A lookup is accepted when `lk_valid` and `lk_ready` are both high, and `rsp_valid` is high exactly in the following cycle. After reset `rsp_valid`, `rf_busy` and `rf_done` are low and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_write | input | 1 | Lookup is a write |
| lk_ready | output | 1 | Lookup can be accepted |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_miss | output | 1 | No valid status entry |
| rsp_fault | output | 1 | Access bits deny the request |
| rsp_pa | output | PA_W | Physical address on success |
| rsp_attr | output | 10 | Entry bits [31:22] |
| rf_valid | input | 1 | Refill request |
| rf_page | input | TAG_W+SLOT_W | Map page (tag and slot) to install |
| rf_entry | input | 32 | New bank entry |
| rf_wired | input | 1 | Pin this page into the left bank |
| rf_ready | output | 1 | Refill can be accepted |
| rf_busy | output | 1 | Refill sequence running |
| rf_done | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach from the ports is a slot pair where the bank about to be replaced is owned by a different tag that holds both of its map pages. Reaching it also requires the incoming tag to own the other bank through only one of its map pages, or the pair to have been pinned by a wired refill. The stimulus reaches these states by installing every aliasing tag in turn into every slot, with both halves of each pair. Each pair therefore rotates through both banks, evicts owners with two valid map pages, and takes sibling refills that must reuse a bank. A wired refill followed by three competing tags then checks that the pinned page survives. After each phase, a full sweep of reads and writes over every map page compares the results against a model kept in the bench.

// File: rtl/vmap_pkg.sv
package vmap_pkg;

  localparam int ENTRY_W = 32;
  localparam int PPN_W   = 22;
  localparam int OWN_W   = 6;
  localparam int ATTR_W  = 10;
  localparam logic [OWN_W-1:0] OWN_NONE = '1;

  typedef enum logic [1:0] {
    NXT_WIRED = 2'b00,
    NXT_RIGHT = 2'b01,
    NXT_LEFT  = 2'b10,
    NXT_RSVD  = 2'b11
  } nxt_e;

  typedef struct packed {
    logic [OWN_W-1:0] left_own;
    logic [OWN_W-1:0] right_own;
    nxt_e             nxt;
  } usage_t;

  typedef struct packed {
    logic             bank;    // 1 = right
    logic             evict;
    logic [OWN_W-1:0] victim;
    usage_t           upd;
  } refill_dec_t;

  localparam usage_t USAGE_INIT = '{left_own: OWN_NONE, right_own: OWN_NONE, nxt: NXT_LEFT};

  // Read needs the access bit; write also needs the top status bit.
  function automatic logic access_ok(input logic [ENTRY_W-1:0] e, input logic wr);
    return e[31] & (~wr | e[30]);
  endfunction

  // Bank choice, victim and updated usage record for one refill.
  function automatic refill_dec_t choose(input usage_t u, input logic [OWN_W-1:0] tag,
                                         input logic wired);
    refill_dec_t d;
    d.bank   = 1'b0;
    d.evict  = 1'b0;
    d.victim = OWN_NONE;
    d.upd    = u;
    if (wired) begin
      d.victim       = u.left_own;
      d.evict        = (u.left_own != tag) && (u.left_own != OWN_NONE);
      d.upd.left_own = tag;
      d.upd.nxt      = NXT_WIRED;
    end else if (u.left_own == tag) begin
      d.bank = 1'b0;
    end else if (u.right_own == tag) begin
      d.bank = 1'b1;
    end else begin
      d.bank   = (u.nxt == NXT_LEFT) ? 1'b0 : 1'b1;
      d.victim = d.bank ? u.right_own : u.left_own;
      d.evict  = (d.victim != OWN_NONE);
      if (d.bank) d.upd.right_own = tag;
      else        d.upd.left_own  = tag;
      if (u.nxt != NXT_WIRED) d.upd.nxt = d.bank ? NXT_LEFT : NXT_RIGHT;
    end
    return d;
  endfunction

endpackage

// File: rtl/vmap_status_ram.sv
module vmap_status_ram #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ent,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_ent
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 2'b00;
    end else if (we) begin
      mem[wr_idx] <= wr_ent;
    end
  end

  assign rd_ent = mem[rd_idx];

  // A write never selects the left bank while claiming right-bank validity mixups:
  // invalidations carry an all-zero entry.
  AST_INVAL_CLEARS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wr_ent[0]) |-> (wr_ent == 2'b00)); // R7
endmodule

// File: rtl/vmap_bank_ram.sv
module vmap_bank_ram #(
  parameter int SLOT_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_ent,
  input  logic              we,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_ent
);
  localparam int DEPTH = 1 << SLOT_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_slot] <= wr_ent;
  end

  assign rd_ent = mem[rd_slot];
endmodule

// File: rtl/vmap_usage_table.sv
module vmap_usage_table
  import vmap_pkg::*;
#(
  parameter int PAIR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAIR_W-1:0] idx,
  output usage_t            rd_rec,
  input  logic              we,
  input  usage_t            wr_rec
);
  localparam int DEPTH = 1 << PAIR_W;

  usage_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= USAGE_INIT;
    end else if (we) begin
      mem[idx] <= wr_rec;
    end
  end

  assign rd_rec = mem[idx];

  AST_NEXT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wr_rec.nxt != NXT_RSVD)); // R6
endmodule

// File: rtl/vmap_refill_ctrl.sv
module vmap_refill_ctrl
  import vmap_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int SLOT_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rf_valid,
  input  logic [TAG_W+SLOT_W-1:0] rf_page,
  input  logic [ENTRY_W-1:0]      rf_entry,
  input  logic                    rf_wired,
  output logic                    rf_ready,
  output logic                    busy,
  output logic                    done,
  output logic [SLOT_W-2:0]       us_idx,
  input  usage_t                  us_rd,
  output logic                    us_we,
  output usage_t                  us_wd,
  output logic                    st_we,
  output logic [TAG_W+SLOT_W-1:0] st_idx,
  output logic [1:0]              st_wd,
  output logic [1:0]              bk_we,
  output logic [SLOT_W-1:0]       bk_slot,
  output logic [ENTRY_W-1:0]      bk_wd
);
  localparam int MP_W   = TAG_W + SLOT_W;
  localparam int PAIR_W = SLOT_W - 1;

  typedef enum logic [2:0] {S_IDLE, S_PICK, S_INV0, S_INV1, S_INST} state_e;

  state_e             state;
  logic [MP_W-1:0]    page_q;
  logic [ENTRY_W-1:0] ent_q;
  logic               wired_q;
  logic               bank_q;
  logic               evict_q;
  logic [OWN_W-1:0]   victim_q;
  usage_t             upd_q;

  logic [TAG_W-1:0]   tag_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [PAIR_W-1:0]  pair_q;
  refill_dec_t        dec;

  assign tag_q  = page_q[MP_W-1:SLOT_W];
  assign slot_q = page_q[SLOT_W-1:0];
  assign pair_q = slot_q[SLOT_W-1:1];
  assign dec    = choose(us_rd, OWN_W'(tag_q), wired_q);

  // Status index of one half of the evicted owner's page.
  function automatic logic [MP_W-1:0] victim_idx(input logic [OWN_W-1:0] v,
                                                 input logic [PAIR_W-1:0] p, input logic half);
    return {v[TAG_W-1:0], p, half};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      done     <= 1'b0;
      page_q   <= '0;
      ent_q    <= '0;
      wired_q  <= 1'b0;
      bank_q   <= 1'b0;
      evict_q  <= 1'b0;
      victim_q <= OWN_NONE;
      upd_q    <= USAGE_INIT;
    end else begin
      done <= (state == S_INST);
      case (state)
        S_IDLE: if (rf_valid) begin
          page_q  <= rf_page;
          ent_q   <= rf_entry;
          wired_q <= rf_wired;
          state   <= S_PICK;
        end
        S_PICK: begin
          bank_q   <= dec.bank;
          evict_q  <= dec.evict;
          victim_q <= dec.victim;
          upd_q    <= dec.upd;
          state    <= S_INV0;
        end
        S_INV0:  state <= S_INV1;
        S_INV1:  state <= S_INST;
        S_INST:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    st_we  = 1'b0;
    st_idx = page_q;
    st_wd  = 2'b00;
    case (state)
      S_INV0: begin st_we = evict_q; st_idx = victim_idx(victim_q, pair_q, 1'b0); end
      S_INV1: begin st_we = evict_q; st_idx = victim_idx(victim_q, pair_q, 1'b1); end
      S_INST: begin st_we = 1'b1;    st_idx = page_q; st_wd = {bank_q, 1'b1}; end
      default: ;
    endcase
  end

  assign us_idx   = pair_q;
  assign us_we    = (state == S_INST);
  assign us_wd    = upd_q;
  assign bk_we    = (state == S_INST) ? (bank_q ? 2'b10 : 2'b01) : 2'b00;
  assign bk_slot  = slot_q;
  assign bk_wd    = ent_q;
  assign busy     = (state != S_IDLE);
  assign rf_ready = ~busy;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)); // R10
  AST_WIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (us_we && us_rd.nxt == NXT_WIRED) |-> (us_wd.nxt == NXT_WIRED)); // R9
  AST_INSTALL_MATCHES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_we != 2'b00) |-> (st_we && st_wd[0] && st_wd[1] == bk_we[1])); // R1
  AST_NO_SELF_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !st_wd[0]) |-> (st_idx[MP_W-1:SLOT_W] != tag_q)); // R7
  AST_VICTIM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INV0 && evict_q) |-> (victim_q < OWN_W'(1 << TAG_W))); // R7
endmodule

// File: rtl/vmap_two_bank.sv
module vmap_two_bank
  import vmap_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int SLOT_W = 6,
  parameter int OFF_W  = 8,
  localparam int VA_W  = TAG_W + SLOT_W + OFF_W,
  localparam int MP_W  = TAG_W + SLOT_W,
  localparam int PA_W  = PPN_W + OFF_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic [VA_W-1:0]     lk_va,
  input  logic                lk_write,
  output logic                lk_ready,
  output logic                rsp_valid,
  output logic                rsp_miss,
  output logic                rsp_fault,
  output logic [PA_W-1:0]     rsp_pa,
  output logic [ATTR_W-1:0]   rsp_attr,
  input  logic                rf_valid,
  input  logic [MP_W-1:0]     rf_page,
  input  logic [ENTRY_W-1:0]  rf_entry,
  input  logic                rf_wired,
  output logic                rf_ready,
  output logic                rf_busy,
  output logic                rf_done
);
  localparam int PAIR_W = SLOT_W - 1;

  logic [1:0]         st_rd;
  logic [ENTRY_W-1:0] bk_rd [2];
  logic               st_we;
  logic [MP_W-1:0]    st_idx;
  logic [1:0]         st_wd;
  logic [1:0]         bk_we;
  logic [SLOT_W-1:0]  bk_slot;
  logic [ENTRY_W-1:0] bk_wd;
  logic [PAIR_W-1:0]  us_idx;
  usage_t             us_rd;
  logic               us_we;
  usage_t             us_wd;

  logic [MP_W-1:0]    lk_page;
  logic [SLOT_W-1:0]  lk_slot;
  logic [ENTRY_W-1:0] sel_ent;
  logic               lk_hit;
  logic               lk_ok;
  logic               lk_take;
  logic               rsp_wr_q;

  function automatic logic [PA_W-1:0] make_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [OFF_W-1:0] off);
    return {ppn, off, 2'b00};
  endfunction

  assign lk_page = lk_va[VA_W-1:OFF_W];
  assign lk_slot = lk_va[OFF_W+SLOT_W-1:OFF_W];

  vmap_status_ram #(.IDX_W(MP_W)) u_status (
    .clk(clk), .rst_n(rst_n), .rd_idx(lk_page), .rd_ent(st_rd),
    .we(st_we), .wr_idx(st_idx), .wr_ent(st_wd));

  for (genvar b = 0; b < 2; b++) begin : g_bank
    vmap_bank_ram #(.SLOT_W(SLOT_W), .DATA_W(ENTRY_W)) u_bank (
      .clk(clk), .rd_slot(lk_slot), .rd_ent(bk_rd[b]),
      .we(bk_we[b]), .wr_slot(bk_slot), .wr_ent(bk_wd));
  end

  vmap_usage_table #(.PAIR_W(PAIR_W)) u_usage (
    .clk(clk), .rst_n(rst_n), .idx(us_idx), .rd_rec(us_rd),
    .we(us_we), .wr_rec(us_wd));

  vmap_refill_ctrl #(.TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rf_valid(rf_valid), .rf_page(rf_page),
    .rf_entry(rf_entry), .rf_wired(rf_wired), .rf_ready(rf_ready),
    .busy(rf_busy), .done(rf_done), .us_idx(us_idx), .us_rd(us_rd),
    .us_we(us_we), .us_wd(us_wd), .st_we(st_we), .st_idx(st_idx),
    .st_wd(st_wd), .bk_we(bk_we), .bk_slot(bk_slot), .bk_wd(bk_wd));

  assign lk_ready = ~rf_busy;
  assign lk_take  = lk_valid & lk_ready;
  assign sel_ent  = st_rd[1] ? bk_rd[1] : bk_rd[0];
  assign lk_hit   = st_rd[0];
  assign lk_ok    = lk_hit & access_ok(sel_ent, lk_write);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
      rsp_attr  <= '0;
      rsp_wr_q  <= 1'b0;
    end else begin
      rsp_valid <= lk_take;
      if (lk_take) begin
        rsp_miss  <= ~lk_hit;
        rsp_fault <= lk_hit & ~lk_ok;
        rsp_pa    <= lk_ok ? make_pa(sel_ent[PPN_W-1:0], lk_va[OFF_W-1:0]) : '0;
        rsp_attr  <= lk_hit ? sel_ent[ENTRY_W-1:ENTRY_W-ATTR_W] : '0;
        rsp_wr_q  <= lk_write;
      end
    end
  end

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lk_valid && lk_ready)); // R11
  AST_MISS_EXCL_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_miss && rsp_fault)); // R4
  AST_WRITE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wr_q && !rsp_miss && !rsp_fault) |-> (rsp_attr[9:8] == 2'b11)); // R4
  AST_PA_CARRIES_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_miss && !rsp_fault) |->
      (rsp_pa[OFF_W+1:0] == {$past(lk_va[OFF_W-1:0]), 2'b00})); // R5
endmodule

// File: tb/vmap_two_bank_test.sv
module vmap_two_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 3, SLOT_W = 3, OFF_W = 8;
  localparam int VA_W = TAG_W + SLOT_W + OFF_W;
  localparam int MP_W = TAG_W + SLOT_W;
  localparam int NMP = 1 << MP_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_write = 1'b0;
  logic [VA_W-1:0] lk_va = '0;
  logic lk_ready, rsp_valid, rsp_miss, rsp_fault;
  logic [31:0] rsp_pa;
  logic [9:0] rsp_attr;
  logic rf_valid = 1'b0, rf_wired = 1'b0;
  logic [MP_W-1:0] rf_page = '0;
  logic [31:0] rf_entry = '0;
  logic rf_ready, rf_busy, rf_done;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [1:0]  m_stat [NMP];
  logic [31:0] m_bank [2][8];
  logic [1:0]  m_nxt [4];
  logic [5:0]  m_own [2][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  vmap_two_bank #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .OFF_W(OFF_W)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_write(lk_write),
    .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
    .rsp_pa(rsp_pa), .rsp_attr(rsp_attr), .rf_valid(rf_valid), .rf_page(rf_page),
    .rf_entry(rf_entry), .rf_wired(rf_wired), .rf_ready(rf_ready), .rf_busy(rf_busy),
    .rf_done(rf_done));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] ent_of(input int t, input int s);
    int h;
    h = t * 8 + s;
    return {2'(h + t), 8'(h * 37 + 11), 22'(h * 1237 + 99)};
  endfunction

  task automatic m_reset();
    for (int i = 0; i < NMP; i++) m_stat[i] = 2'b00;
    for (int p = 0; p < 4; p++) begin
      m_nxt[p] = 2'b10; m_own[0][p] = 6'h3F; m_own[1][p] = 6'h3F;
    end
  endtask

  task automatic m_refill(input logic [5:0] page, input logic [31:0] e, input logic wired);
    logic [5:0] tg, vic;
    int s, p, b;
    logic ev;
    tg = {3'b000, page[5:3]}; s = int'(page[2:0]); p = s / 2; ev = 1'b0; vic = 6'h3F; b = 0;
    if (wired) begin
      b = 0;
      if (m_own[0][p] != tg && m_own[0][p] != 6'h3F) begin ev = 1'b1; vic = m_own[0][p]; end
      m_own[0][p] = tg; m_nxt[p] = 2'b00;
    end else if (m_own[0][p] == tg) b = 0;
    else if (m_own[1][p] == tg) b = 1;
    else begin
      b = (m_nxt[p] == 2'b10) ? 0 : 1;
      if (m_own[b][p] != 6'h3F) begin ev = 1'b1; vic = m_own[b][p]; end
      m_own[b][p] = tg;
      if (m_nxt[p] != 2'b00) m_nxt[p] = (b == 1) ? 2'b10 : 2'b01;
    end
    if (ev) begin
      m_stat[{vic[2:0], 2'(p), 1'b0}] = 2'b00;
      m_stat[{vic[2:0], 2'(p), 1'b1}] = 2'b00;
    end
    m_bank[b][s] = e;
    m_stat[page] = {1'(b), 1'b1};
  endtask

  function automatic logic [63:0] m_expect(input logic [5:0] page, input logic [7:0] off,
                                           input logic wr);
    logic [31:0] e;
    logic miss, fault;
    logic [31:0] pa;
    logic [9:0] at;
    miss = ~m_stat[page][0]; fault = 1'b0; pa = '0; at = '0;
    if (!miss) begin
      e = m_bank[m_stat[page][1]][page[2:0]];
      at = e[31:22];
      fault = ~e[31] | (wr & ~e[30]);
      if (!fault) pa = {e[21:0], off, 2'b00};
    end
    return {19'd0, 1'b1, miss, fault, pa, at};
  endfunction

  task automatic lookup(input logic [5:0] page, input logic [7:0] off, input logic wr,
                        input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = {page, off}; lk_write = wr;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(req, {19'd0, rsp_valid, rsp_miss, rsp_fault, rsp_pa, rsp_attr}, m_expect(page, off, wr));
  endtask

  task automatic refill(input logic [5:0] page, input logic [31:0] e, input logic wired,
                        input bit timing);
    int busy_n, nready_n, waited;
    @(negedge clk);
    rf_valid = 1'b1; rf_page = page; rf_entry = e; rf_wired = wired;
    @(negedge clk);
    rf_valid = 1'b0; rf_wired = 1'b0;
    m_refill(page, e, wired);
    busy_n = 0; nready_n = 0; waited = 0;
    while (!rf_done && waited < 20) begin
      if (rf_busy) busy_n++;
      if (!lk_ready && !rf_ready) nready_n++;
      @(negedge clk);
      waited++;
    end
    if (timing) begin
      chk("R10 busy cycles", 64'(busy_n), 64'd4);
      chk("R10 lookups stalled while busy", 64'(nready_n), 64'd4);
      chk("R10 done pulse with ready", {61'd0, rf_done, rf_busy, lk_ready}, 64'b101);
      @(negedge clk);
      chk("R10 done lasts one cycle", 64'(rf_done), 64'd0);
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < NMP; i++)
      for (int w = 0; w < 2; w++)
        lookup(6'(i), 8'(i * 7 + w * 3), 1'(w), req);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset outputs", {59'd0, rsp_valid, rf_busy, rf_done, lk_ready, rf_ready},
        64'b00011);
    sweep("R1 reset all miss");

    for (int t = 0; t < 8; t++) begin
      for (int s = 0; s < 8; s++) begin
        refill({3'(t), 3'(s)}, ent_of(t, s), 1'b0, (t == 0 && s == 0) || (t == 5 && s == 3));
        lookup({3'(t), 3'(s)}, 8'(s * 19 + t), 1'b0, "R2 R5 installed entry");
        if (s % 2 == 1)
          lookup({3'(t), 3'(s - 1)}, 8'h5A, 1'b0, "R8 sibling map page kept");
        if (t >= 1)
          lookup({3'(t - 1), 3'(s)}, 8'h21, 1'b0, "R3 two aliases coexist");
        if (t >= 2)
          lookup({3'(t - 2), 3'(s)}, 8'h33, 1'b1, "R6 R7 oldest alias evicted");
      end
    end
    sweep("R3 R4 R5 R7 R11 after full rotation");

    refill(6'({3'd5, 3'd0}), 32'hC000_1234, 1'b1, 1'b1);
    lookup(6'({3'd5, 3'd0}), 8'h10, 1'b1, "R9 wired page installed");
    for (int t = 1; t < 4; t++) begin
      refill({3'(t), 3'd0}, ent_of(t, 0) | 32'h8000_0000, 1'b0, 1'b0);
      lookup(6'({3'd5, 3'd0}), 8'(t), 1'b0, "R9 wired page survives");
      lookup({3'(t), 3'd0}, 8'h44, 1'b0, "R9 competitor goes right");
    end
    sweep("R4 R6 R7 R9 after wired pin");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule